// File: doc/BRIEF.md
# Baseband Interrupt Status Controller

This block collects the interrupt sources of a short-range radio baseband and presents them to firmware through a small register window. Eleven single-cycle event pulses, covering packet reception milestones, receive check failures, transmit completions and compare-timer expiries, are captured in sticky flags. Firmware acknowledges a flag by writing a 1 to the matching bit of a write-only acknowledge register. Two FIFO watermark conditions are handled differently. They are not captured. Their status bits show the live level of the condition inputs, and they fall again once firmware has serviced the FIFO.

A mask register selects which status bits may raise an interrupt. The masked event flags are ORed onto one registered interrupt line. The masked FIFO conditions are ORed onto a second registered line. The register bus is synchronous: address, write enable and write data are sampled on the clock edge, and read data is returned combinationally from the current state.

Top module: `bbint_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the status word and mask read 0 and both interrupt outputs are low.
- R2: A pulse on event input N (N = 0..10) sets status bit N on the next clock edge, and the bit stays set with no further stimulus. The order from bit 0 is: payload complete, payload header ready, packet header ready, FEC fail, CRC fail, HEC fail, correlator trigger, TX packet complete, RX/TX start timer, access code TX complete, general-purpose timer.
- R3: A write to byte offset 0x5C with bit N at 1 (N = 0..10) clears sticky status bit N. Bits written as 0 leave their flags unchanged, and bits 31..11 of that write have no effect.
- R4: Status bit 11 shows the RX FIFO almost-full input (fifo_lvl[0]) and bit 12 shows the TX FIFO almost-empty input (fifo_lvl[1]) in the same cycle, with no latching. A write to 0x5C does not change them.
- R5: The mask register at byte offset 0x58 can be read and written. Bits 12..0 are stored and bits 31..13 read as 0.
- R6: irq_pkt is high one clock edge after any status bit 10..0 is set while its mask bit is 1, and low one edge after no such bit remains.
- R7: irq_fifo is high one clock edge after status bit 11 or 12 is high while its mask bit is 1, and low one edge after no such bit remains.
- R8: If an event pulse and an acknowledge of the same bit arrive on the same edge, the bit ends up set.
- R9: The status register at byte offset 0x54 is read-only, and writes to it change nothing. Status bits 31..13 read as 0, and a read of offset 0x5C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_pulse | input | 11 | Event pulses, one bit per sticky status flag |
| fifo_lvl | input | 2 | FIFO conditions: [0] RX almost full, [1] TX almost empty |
| irq_pkt | output | 1 | Registered OR of the masked event flags |
| irq_fifo | output | 1 | Registered OR of the masked FIFO conditions |

## Verification
Event flags, acknowledges and mask writes take effect on the edge that samples them, so the read-back is checked after that edge. FIFO status bits follow their inputs in the same cycle and are checked a few time units after the input changes, with no edge in between. Both interrupt lines lag their causes by one further edge. The bench checks each line once before that edge, where it must still show the old value, and once after it. All inputs are driven on the falling edge and every sample is taken just after it, so every check falls a known number of rising edges after its stimulus.

// File: rtl/bbint_pkg.sv
package bbint_pkg;
  localparam int BB_DATA_W = 32;
  localparam int BB_ADDR_W = 8;
  localparam int BB_EVT_N  = 11;
  localparam int BB_FIFO_N = 2;
  localparam logic [BB_ADDR_W-1:0] BB_OFS_STATUS = 8'h54;
  localparam logic [BB_ADDR_W-1:0] BB_OFS_MASK   = 8'h58;
  localparam logic [BB_ADDR_W-1:0] BB_OFS_ACK    = 8'h5C;
endpackage

// File: rtl/bbint_rst_sync.sv
module bbint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bbint_evt_latch.sv
module bbint_evt_latch #(
  parameter int EVT_N = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [EVT_N-1:0] ack_i,
  output logic [EVT_N-1:0] flag_o
);
  logic [EVT_N-1:0] flag_q;
  logic [EVT_N-1:0] flag_d;

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    // set has priority over acknowledge so a coincident event is kept
    always_comb begin
      flag_d[i] = evt_i[i] | (flag_q[i] & ~ack_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag_q[i]);
    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !ack_i[i]) |=> flag_q[i]);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !evt_i[i]) |=> !flag_q[i]);
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !evt_i[i]) |=> !flag_q[i]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && evt_i[i]) |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bbint_regif.sv
module bbint_regif #(
  parameter int                  DATA_W     = 32,
  parameter int                  ADDR_W     = 8,
  parameter int                  EVT_N      = 11,
  parameter int                  FIFO_N     = 2,
  parameter logic [ADDR_W-1:0]   OFS_STATUS = 8'h54,
  parameter logic [ADDR_W-1:0]   OFS_MASK   = 8'h58,
  parameter logic [ADDR_W-1:0]   OFS_ACK    = 8'h5C,
  localparam int                 STS_W      = EVT_N + FIFO_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STS_W-1:0]  sts_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [EVT_N-1:0]  ack_o,
  output logic [STS_W-1:0]  mask_o
);
  localparam int PAD_W = DATA_W - STS_W;

  logic [STS_W-1:0] mask_q;
  logic [STS_W-1:0] mask_d;
  logic             mask_wr;
  logic             ack_wr;

  always_comb begin
    mask_wr = we_i && (addr_i == OFS_MASK);
    ack_wr  = we_i && (addr_i == OFS_ACK);
    mask_d  = mask_wr ? wdata_i[STS_W-1:0] : mask_q;
    ack_o   = ack_wr ? wdata_i[EVT_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_comb begin
    unique case (addr_i)
      OFS_STATUS: rdata_o = {{PAD_W{1'b0}}, sts_i};
      OFS_MASK:   rdata_o = {{PAD_W{1'b0}}, mask_q};
      default:    rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;

  assert_mask_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata_i[STS_W-1:0])));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/bbint_irq_gen.sv
module bbint_irq_gen #(
  parameter int  EVT_N  = 11,
  parameter int  FIFO_N = 2,
  localparam int STS_W  = EVT_N + FIFO_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] sts_i,
  input  logic [STS_W-1:0] mask_i,
  output logic             irq_pkt_o,
  output logic             irq_fifo_o
);
  logic [STS_W-1:0] live;
  logic             pkt_d, fifo_d, pkt_q, fifo_q;

  always_comb begin
    live   = sts_i & mask_i;
    pkt_d  = |live[EVT_N-1:0];
    fifo_d = |live[STS_W-1:EVT_N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q  <= 1'b0;
      fifo_q <= 1'b0;
    end else begin
      pkt_q  <= pkt_d;
      fifo_q <= fifo_d;
    end
  end

  assign irq_pkt_o  = pkt_q;
  assign irq_fifo_o = fifo_q;

  assert_irq_pkt_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_i[EVT_N-1:0] & mask_i[EVT_N-1:0])) |=> irq_pkt_o);
  assert_irq_pkt_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_i[EVT_N-1:0] & mask_i[EVT_N-1:0])) |=> !irq_pkt_o);
  assert_irq_fifo_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_i[STS_W-1:EVT_N] & mask_i[STS_W-1:EVT_N])) |=> irq_fifo_o);
  assert_irq_fifo_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_i[STS_W-1:EVT_N] & mask_i[STS_W-1:EVT_N])) |=> !irq_fifo_o);
endmodule

// File: rtl/bbint_ctrl.sv
module bbint_ctrl
  import bbint_pkg::*;
#(
  parameter int                  DATA_W     = BB_DATA_W,
  parameter int                  ADDR_W     = BB_ADDR_W,
  parameter int                  EVT_N      = BB_EVT_N,
  parameter int                  FIFO_N     = BB_FIFO_N,
  parameter logic [ADDR_W-1:0]   OFS_STATUS = BB_OFS_STATUS,
  parameter logic [ADDR_W-1:0]   OFS_MASK   = BB_OFS_MASK,
  parameter logic [ADDR_W-1:0]   OFS_ACK    = BB_OFS_ACK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic [FIFO_N-1:0] fifo_lvl,
  output logic              irq_pkt,
  output logic              irq_fifo
);
  localparam int STS_W = EVT_N + FIFO_N;

  logic             rst_n_int;
  logic [EVT_N-1:0] ack;
  logic [EVT_N-1:0] flags;
  logic [STS_W-1:0] status;
  logic [STS_W-1:0] mask;

  bbint_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bbint_evt_latch #(.EVT_N(EVT_N)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .evt_i  (evt_pulse),
    .ack_i  (ack),
    .flag_o (flags)
  );

  // FIFO conditions are shown live; only the event flags are latched
  assign status = {fifo_lvl, flags};

  bbint_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_N(EVT_N), .FIFO_N(FIFO_N),
    .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK), .OFS_ACK(OFS_ACK)
  ) u_regif (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .addr_i  (bus_addr),
    .we_i    (bus_we),
    .wdata_i (bus_wdata),
    .sts_i   (status),
    .rdata_o (bus_rdata),
    .ack_o   (ack),
    .mask_o  (mask)
  );

  bbint_irq_gen #(.EVT_N(EVT_N), .FIFO_N(FIFO_N)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sts_i      (status),
    .mask_i     (mask),
    .irq_pkt_o  (irq_pkt),
    .irq_fifo_o (irq_fifo)
  );
endmodule

// File: tb/tb_bbint_ctrl.sv
module tb_bbint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STS = 8'h54;
  localparam logic [7:0] A_MSK = 8'h58;
  localparam logic [7:0] A_ACK = 8'h5C;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [10:0] evt_pulse;
  logic [1:0]  fifo_lvl;
  logic        irq_pkt;
  logic        irq_fifo;

  int n_chk;
  int n_fail;
  bit done;

  bbint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .fifo_lvl(fifo_lvl), .irq_pkt(irq_pkt), .irq_fifo(irq_fifo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [10:0] evt;
    logic [31:0] ack;
    logic [31:0] msk;
    logic [1:0]  fifo;
    logic [31:0] exp_sts;
    logic        exp_pkt;
    logic        exp_fifo;
  } vec_t;

  // each vector: event pulse, acknowledge write, mask write, FIFO levels, then check
  localparam vec_t VECS [6] = '{
    '{11'h001, 32'h0000_0000, 32'h0000_0000, 2'b00, 32'h0000_0001, 1'b0, 1'b0},
    '{11'h400, 32'h0000_0000, 32'h0000_0400, 2'b00, 32'h0000_0401, 1'b1, 1'b0},
    '{11'h000, 32'h0000_0400, 32'h0000_0400, 2'b00, 32'h0000_0001, 1'b0, 1'b0},
    '{11'h0F0, 32'hFFFF_F800, 32'h0000_1000, 2'b10, 32'h0000_10F1, 1'b0, 1'b1},
    '{11'h002, 32'h0000_00F1, 32'h0000_0802, 2'b01, 32'h0000_0802, 1'b1, 1'b1},
    '{11'h000, 32'h0000_07FF, 32'h0000_1FFF, 2'b00, 32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    evt_pulse = '0; fifo_lvl = '0;
    repeat (3) @(negedge clk);
    // R1: reset held
    chk("R1 irq_pkt in reset", {31'b0, irq_pkt}, 32'h0);
    rd(A_STS, d); chk("R1 status in reset", d, 32'h0);
    rst_n = 1'b1;
    repeat (4) step();
    rd(A_STS, d); chk("R1 status after reset", d, 32'h0);
    rd(A_MSK, d); chk("R1 mask after reset", d, 32'h0);
    chk("R1 irqs after reset", {30'b0, irq_fifo, irq_pkt}, 32'h0);

    // vector table: R2, R3, R4, R6, R7
    foreach (VECS[i]) begin
      evt_pulse = VECS[i].evt;
      step();
      evt_pulse = '0;
      wr(A_ACK, VECS[i].ack);
      wr(A_MSK, VECS[i].msk);
      fifo_lvl = VECS[i].fifo;
      step();
      rd(A_STS, d);
      chk($sformatf("R2/R3/R4 vec%0d status", i), d, VECS[i].exp_sts);
      chk($sformatf("R6 vec%0d irq_pkt", i), {31'b0, irq_pkt}, {31'b0, VECS[i].exp_pkt});
      chk($sformatf("R7 vec%0d irq_fifo", i), {31'b0, irq_fifo}, {31'b0, VECS[i].exp_fifo});
    end

    // R6: irq lags the flag by one edge (mask is now 0x1FFF, status 0)
    evt_pulse = 11'h001;
    step();
    evt_pulse = '0;
    rd(A_STS, d); chk("R2 flag set after one edge", d, 32'h1);
    chk("R6 irq_pkt not yet", {31'b0, irq_pkt}, 32'h0);
    step();
    chk("R6 irq_pkt after second edge", {31'b0, irq_pkt}, 32'h1);

    // R4/R7: FIFO bit live, interrupt one edge later
    fifo_lvl = 2'b01;
    rd(A_STS, d); chk("R4 fifo bit11 same cycle", d, 32'h801);
    chk("R7 irq_fifo not yet", {31'b0, irq_fifo}, 32'h0);
    step();
    chk("R7 irq_fifo after edge", {31'b0, irq_fifo}, 32'h1);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STS, d); chk("R4 ack leaves fifo bit", d, 32'h800);
    fifo_lvl = 2'b00;
    rd(A_STS, d); chk("R4 fifo bit falls with input", d, 32'h0);
    step();
    chk("R6/R7 irqs low once sources gone", {30'b0, irq_fifo, irq_pkt}, 32'h0);

    // R8: coincident event and acknowledge
    evt_pulse = 11'h008;
    wr(A_ACK, 32'h0000_0008);
    evt_pulse = '0;
    rd(A_STS, d); chk("R8 set wins", d, 32'h8);
    repeat (20) step();
    rd(A_STS, d); chk("R2 flag persists", d, 32'h8);
    wr(A_ACK, 32'h0000_0004);
    rd(A_STS, d); chk("R3 other bit ack leaves flag", d, 32'h8);
    wr(A_ACK, 32'h0000_0008);
    rd(A_STS, d); chk("R3 ack clears flag", d, 32'h0);

    // R9: status read-only, ack reads 0
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, d); chk("R9 status write ignored", d, 32'h0);
    rd(A_ACK, d); chk("R9 ack reads zero", d, 32'h0);
    fifo_lvl = 2'b11;
    rd(A_STS, d); chk("R9 reserved status bits zero", d & 32'hFFFF_E000, 32'h0);
    fifo_lvl = 2'b00;

    // R5: mask width
    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, d); chk("R5 mask upper bits zero", d, 32'h1FFF);
    wr(A_MSK, 32'h0000_0A5A);
    rd(A_MSK, d); chk("R5 mask readback", d, 32'h0A5A);

    // R1: reset in mid-run
    evt_pulse = 11'h002;
    step();
    evt_pulse = '0;
    step();
    chk("R6 irq before reset", {31'b0, irq_pkt}, 32'h1);
    rst_n = 1'b0;
    #1;
    chk("R1 irq_pkt on async reset", {31'b0, irq_pkt}, 32'h0);
    rd(A_STS, d); chk("R1 status on async reset", d, 32'h0);
    rd(A_MSK, d); chk("R1 mask on async reset", d, 32'h0);
    step();
    rst_n = 1'b1;
    repeat (4) step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule